// File: doc/BRIEF.md
# Multi-PID TLB Match and Permission Checker

This block looks up a small, fully associative, software-loaded translation table. A request carries a virtual address, an access kind (load, store or instruction fetch), a privilege mode, two address-space bits (one for fetches, one for data) and three process IDs. Every entry is compared in parallel. The comparison uses the entry's power-of-two page size, its process tag, its address-space bit and its protection byte. One entry is chosen by a priority rule. Its translated address, its permission nibble and a result code are registered and returned one cycle after the request.

Software fills entries through a single-cycle write port. An entry written with its valid bit clear is removed from the table. A mode input picks between two scan policies:
- **first-grant**: the first entry that grants the access wins.
- **first-match**: the first entry that matches wins, even if it denies the access.

Top module: `tlb_lookup`

## Requirements
- R1: An entry with page shift s matches an address only when the address and the entry's page number agree in every bit at position s and above. The bits below s are ignored.
- R2: The translated address takes the entry's real page number in bits s and above, and the request address in bits below s.
- R3: An entry whose tag is zero matches any process ID. Any other tag must equal the primary ID, or the second ID when that ID is nonzero, or the third ID when that ID is nonzero.
- R4: The permission nibble is taken from the protection byte: bits [3:0] in user mode, bits [7:4] in supervisor mode. Within the nibble, bit 0 grants loads, bit 1 grants stores and bit 2 grants fetches.
- R5: An entry's address-space bit must equal the instruction-space bit for fetches and the data-space bit for loads and stores. Otherwise the entry does not match.
- R6: The result code is 0 for granted, 1 for miss, 2 for a matching load or store without permission, and 3 for a matching fetch without execute permission.
- R7: In first-grant mode (scan mode input low), the lowest-index granting entry is reported. When no entry grants, the lowest-index matching entry and its denial code are reported.
- R8: In first-match mode (scan mode input high), the lowest-index matching entry is reported with its own code, whether or not a later entry would grant.
- R9: When several entries qualify under the active mode, the lowest index wins.
- R10: The response valid flag rises one cycle after a valid request and holds no other time. The hit flag is set exactly when the code is not miss. On a miss, the address and permission outputs are zero.
- R11: After reset no entry is valid, and every lookup misses.
- R12: Writing an entry with the valid bit clear removes it, and later lookups of its page miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_va_i | input | ADDR_W | Virtual address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| req_user_i | input | 1 | 1 user mode, 0 supervisor |
| req_is_i | input | 1 | Instruction address-space bit |
| req_ds_i | input | 1 | Data address-space bit |
| pid0_i | input | PID_W | Primary process ID |
| pid1_i | input | PID_W | Second process ID, 0 disables it |
| pid2_i | input | PID_W | Third process ID, 0 disables it |
| first_match_i | input | 1 | 1 first-match scan, 0 first-grant scan |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry index |
| wr_valid_i | input | 1 | Valid bit to store |
| wr_epn_i | input | ADDR_W | Virtual page number (address-aligned) |
| wr_rpn_i | input | ADDR_W | Real page number (address-aligned) |
| wr_shift_i | input | SHIFT_W | log2 of page size |
| wr_tag_i | input | PID_W | Process tag, 0 is wildcard |
| wr_as_i | input | 1 | Address-space bit |
| wr_prot_i | input | 8 | Protection byte |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Some entry reported |
| rsp_code_o | output | 2 | Result code |
| rsp_pa_o | output | ADDR_W | Translated address |
| rsp_perm_o | output | 4 | Selected permission nibble |

## Verification
The hardest case to reach is the split between the two scan policies. It only shows when a lower-index entry matches but denies the access while a higher-index entry for the same page grants it. The bench loads exactly that pair and repeats one store under both modes. It then removes the granting entry to force the denial fallback of first-grant mode. Process-ID selection is reached by keeping the primary ID wrong and carrying the entry's tag only in the second or third ID.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] RES_GRANT   = 2'd0;
  localparam logic [1:0] RES_MISS    = 2'd1;
  localparam logic [1:0] RES_RW_DENY = 2'd2;
  localparam logic [1:0] RES_X_DENY  = 2'd3;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int PID_W   = 8,
  parameter int SHIFT_W = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic [ADDR_W-1:0]  wr_epn_i,
  input  logic [ADDR_W-1:0]  wr_rpn_i,
  input  logic [SHIFT_W-1:0] wr_shift_i,
  input  logic [PID_W-1:0]   wr_tag_i,
  input  logic               wr_as_i,
  input  logic [7:0]         wr_prot_i,
  output logic               vld_o   [ENTRIES],
  output logic [ADDR_W-1:0]  epn_o   [ENTRIES],
  output logic [ADDR_W-1:0]  rpn_o   [ENTRIES],
  output logic [SHIFT_W-1:0] shift_o [ENTRIES],
  output logic [PID_W-1:0]   tag_o   [ENTRIES],
  output logic               as_o    [ENTRIES],
  output logic [7:0]         prot_o  [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]   <= 1'b0;
        epn_o[g]   <= '0;
        rpn_o[g]   <= '0;
        shift_o[g] <= '0;
        tag_o[g]   <= '0;
        as_o[g]    <= 1'b0;
        prot_o[g]  <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_o[g]   <= wr_valid_i;
        epn_o[g]   <= wr_epn_i;
        rpn_o[g]   <= wr_rpn_i;
        shift_o[g] <= wr_shift_i;
        tag_o[g]   <= wr_tag_i;
        as_o[g]    <= wr_as_i;
        prot_o[g]  <= wr_prot_i;
      end
    end
  end
endmodule

// File: rtl/tlb_entry_check.sv
module tlb_entry_check
  import tlb_lookup_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PID_W   = 8,
  parameter int SHIFT_W = 5
) (
  input  logic               vld_i,
  input  logic [ADDR_W-1:0]  epn_i,
  input  logic [ADDR_W-1:0]  rpn_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [PID_W-1:0]   tag_i,
  input  logic               as_i,
  input  logic [7:0]         prot_i,
  input  logic [ADDR_W-1:0]  va_i,
  input  logic [1:0]         kind_i,
  input  logic               user_i,
  input  logic               is_i,
  input  logic               ds_i,
  input  logic [PID_W-1:0]   pid0_i,
  input  logic [PID_W-1:0]   pid1_i,
  input  logic [PID_W-1:0]   pid2_i,
  output logic               match_o,
  output logic               grant_o,
  output logic [ADDR_W-1:0]  pa_o,
  output logic [3:0]         perm_o
);
  logic [ADDR_W-1:0] page_mask;
  logic addr_hit, tag_hit, space_bit, allow;

  always_comb begin
    page_mask = ~((ADDR_W'(1) << shift_i) - ADDR_W'(1));
    addr_hit  = ((va_i ^ epn_i) & page_mask) == '0;
    // zero tag is a wildcard; secondary IDs only count when nonzero
    tag_hit   = (tag_i == '0) || (tag_i == pid0_i) ||
                ((pid1_i != '0) && (tag_i == pid1_i)) ||
                ((pid2_i != '0) && (tag_i == pid2_i));
    space_bit = (kind_i == ACC_FETCH) ? is_i : ds_i;
    match_o   = vld_i && addr_hit && tag_hit && (as_i == space_bit);
    perm_o    = user_i ? prot_i[3:0] : prot_i[7:4];
    case (kind_i)
      ACC_FETCH: allow = perm_o[2];
      ACC_STORE: allow = perm_o[1];
      default:   allow = perm_o[0];
    endcase
    grant_o = match_o && allow;
    pa_o    = (rpn_i & page_mask) | (va_i & ~page_mask);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_i,
  input  logic [ENTRIES-1:0] grant_i,
  input  logic               first_match_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   sel_o
);
  logic [ENTRIES-1:0] cand;

  always_comb begin
    // first-grant mode falls back to matches when nothing grants
    cand  = (first_match_i || grant_i == '0) ? match_i : grant_i;
    any_o = 1'b0;
    sel_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any_o = 1'b1;
        sel_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int PID_W    = 8,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int SHIFT_W = $clog2(ADDR_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_va_i,
  input  logic [1:0]         req_kind_i,
  input  logic               req_user_i,
  input  logic               req_is_i,
  input  logic               req_ds_i,
  input  logic [PID_W-1:0]   pid0_i,
  input  logic [PID_W-1:0]   pid1_i,
  input  logic [PID_W-1:0]   pid2_i,
  input  logic               first_match_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic [ADDR_W-1:0]  wr_epn_i,
  input  logic [ADDR_W-1:0]  wr_rpn_i,
  input  logic [SHIFT_W-1:0] wr_shift_i,
  input  logic [PID_W-1:0]   wr_tag_i,
  input  logic               wr_as_i,
  input  logic [7:0]         wr_prot_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [1:0]         rsp_code_o,
  output logic [ADDR_W-1:0]  rsp_pa_o,
  output logic [3:0]         rsp_perm_o
);
  logic               e_vld   [ENTRIES];
  logic [ADDR_W-1:0]  e_epn   [ENTRIES];
  logic [ADDR_W-1:0]  e_rpn   [ENTRIES];
  logic [SHIFT_W-1:0] e_shift [ENTRIES];
  logic [PID_W-1:0]   e_tag   [ENTRIES];
  logic               e_as    [ENTRIES];
  logic [7:0]         e_prot  [ENTRIES];

  logic [ENTRIES-1:0] match, grant;
  logic [ADDR_W-1:0]  pa   [ENTRIES];
  logic [3:0]         perm [ENTRIES];
  logic               sel_any;
  logic [IDX_W-1:0]   sel;
  logic [1:0]         nxt_code;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PID_W(PID_W), .SHIFT_W(SHIFT_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_epn_i, .wr_rpn_i,
    .wr_shift_i, .wr_tag_i, .wr_as_i, .wr_prot_i,
    .vld_o(e_vld), .epn_o(e_epn), .rpn_o(e_rpn), .shift_o(e_shift),
    .tag_o(e_tag), .as_o(e_as), .prot_o(e_prot)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    tlb_entry_check #(
      .ADDR_W(ADDR_W), .PID_W(PID_W), .SHIFT_W(SHIFT_W)
    ) u_chk (
      .vld_i(e_vld[g]), .epn_i(e_epn[g]), .rpn_i(e_rpn[g]),
      .shift_i(e_shift[g]), .tag_i(e_tag[g]), .as_i(e_as[g]),
      .prot_i(e_prot[g]), .va_i(req_va_i), .kind_i(req_kind_i),
      .user_i(req_user_i), .is_i(req_is_i), .ds_i(req_ds_i),
      .pid0_i, .pid1_i, .pid2_i,
      .match_o(match[g]), .grant_o(grant[g]), .pa_o(pa[g]), .perm_o(perm[g])
    );
  end

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match_i(match), .grant_i(grant), .first_match_i,
    .any_o(sel_any), .sel_o(sel)
  );

  always_comb begin
    if (!sel_any)                     nxt_code = RES_MISS;
    else if (grant[sel])              nxt_code = RES_GRANT;
    else if (req_kind_i == ACC_FETCH) nxt_code = RES_X_DENY;
    else                              nxt_code = RES_RW_DENY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_code_o  <= RES_MISS;
      rsp_pa_o    <= '0;
      rsp_perm_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o  <= sel_any;
        rsp_code_o <= nxt_code;
        rsp_pa_o   <= sel_any ? pa[sel] : '0;
        rsp_perm_o <= sel_any ? perm[sel] : '0;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
  import tlb_lookup_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [1:0]        rsp_code_o,
  input logic [ADDR_W-1:0] rsp_pa_o,
  input logic [3:0]        rsp_perm_o
);
  p_rsp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_hit_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o == (rsp_code_o != RES_MISS)));
  p_miss_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == RES_MISS) |-> (rsp_pa_o == '0 && rsp_perm_o == '0));
  p_xdeny_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i != ACC_FETCH) |=> rsp_code_o != RES_X_DENY);
  p_rwdeny_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == ACC_FETCH) |=> rsp_code_o != RES_RW_DENY);
  p_grant_perm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == ACC_STORE) |=>
      (rsp_code_o != RES_GRANT || rsp_perm_o[1]));
endmodule

bind tlb_lookup tlb_lookup_chk #(.ADDR_W(ADDR_W)) u_tlb_lookup_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_kind_i(req_kind_i), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
  .rsp_code_o(rsp_code_o), .rsp_pa_o(rsp_pa_o), .rsp_perm_o(rsp_perm_o)
);

// File: tb/tlb_lookup_tb_top.sv
module tlb_lookup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int ADDR_W = 32;
  localparam int PID_W = 8;
  localparam int IDX_W = 3;
  localparam int SHIFT_W = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_user_i = 0, req_is_i = 0, req_ds_i = 0, first_match_i = 0;
  logic [ADDR_W-1:0] req_va_i = '0, wr_epn_i = '0, wr_rpn_i = '0;
  logic [1:0] req_kind_i = '0;
  logic [PID_W-1:0] pid0_i = '0, pid1_i = '0, pid2_i = '0, wr_tag_i = '0;
  logic wr_en_i = 0, wr_valid_i = 0, wr_as_i = 0;
  logic [IDX_W-1:0] wr_idx_i = '0;
  logic [SHIFT_W-1:0] wr_shift_i = '0;
  logic [7:0] wr_prot_i = '0;
  logic rsp_valid_o, rsp_hit_o;
  logic [1:0] rsp_code_o;
  logic [ADDR_W-1:0] rsp_pa_o;
  logic [3:0] rsp_perm_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlb_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PID_W(PID_W)) dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(int idx, bit vld, logic [31:0] epn, logic [31:0] rpn,
                     int sh, logic [7:0] tag, bit as, logic [7:0] prot);
    wr_en_i = 1; wr_idx_i = IDX_W'(idx); wr_valid_i = vld; wr_epn_i = epn;
    wr_rpn_i = rpn; wr_shift_i = SHIFT_W'(sh); wr_tag_i = tag; wr_as_i = as;
    wr_prot_i = prot;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < ENTRIES; i++) put(i, 0, '0, '0, 0, '0, 0, '0);
  endtask

  // kind: 0 load, 1 store, 2 fetch
  task automatic look(logic [31:0] va, logic [1:0] kind, bit user, bit is, bit ds,
                      logic [7:0] p0, logic [7:0] p1, logic [7:0] p2, bit fm);
    req_valid_i = 1; req_va_i = va; req_kind_i = kind; req_user_i = user;
    req_is_i = is; req_ds_i = ds; pid0_i = p0; pid1_i = p1; pid2_i = p2;
    first_match_i = fm;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic t_reset();
    check("R10 valid low after reset", rsp_valid_o, 0);
    look(32'h1000_0000, 0, 0, 0, 0, 8'd5, 0, 0, 0);
    check("R11 empty table misses", rsp_code_o, 1);
    check("R11 no hit", rsp_hit_o, 0);
  endtask

  task automatic t_translate();
    clear_all();
    put(0, 1, 32'h1000_0000, 32'h8000_0000, 12, 8'd5, 0, 8'h77);
    put(1, 1, 32'h2000_0000, 32'h40A0_0123, 20, 8'd5, 0, 8'h77);
    look(32'h1000_0ABC, 0, 0, 0, 0, 8'd5, 0, 0, 0);
    check("R6 load granted", rsp_code_o, 0);
    check("R2 4K translate", rsp_pa_o, 32'h8000_0ABC);
    check("R10 valid one cycle later", rsp_valid_o, 1);
    @(negedge clk_i);
    check("R10 valid drops", rsp_valid_o, 0);
    look(32'h1000_1ABC, 0, 0, 0, 0, 8'd5, 0, 0, 0);
    check("R1 next page misses", rsp_code_o, 1);
    check("R10 miss pa zero", rsp_pa_o, 0);
    look(32'h200F_1234, 0, 0, 0, 0, 8'd5, 0, 0, 0);
    check("R2 1M translate", rsp_pa_o, 32'h40AF_1234);
    check("R1 1M page hit", rsp_hit_o, 1);
  endtask

  task automatic t_pid();
    clear_all();
    put(0, 1, 32'h1000_0000, 32'h8000_0000, 12, 8'd9, 0, 8'h77);
    put(1, 1, 32'h2000_0000, 32'h9000_0000, 12, 8'd0, 0, 8'h77);
    look(32'h1000_0004, 0, 0, 0, 0, 8'd5, 8'd0, 8'd0, 0);
    check("R3 tag mismatch misses", rsp_code_o, 1);
    look(32'h1000_0004, 0, 0, 0, 0, 8'd5, 8'd9, 8'd0, 0);
    check("R3 second id hits", rsp_code_o, 0);
    look(32'h1000_0004, 0, 0, 0, 0, 8'd5, 8'd0, 8'd9, 0);
    check("R3 third id hits", rsp_code_o, 0);
    look(32'h2000_0008, 0, 0, 0, 0, 8'd3, 8'd0, 8'd0, 0);
    check("R3 zero tag wildcard", rsp_pa_o, 32'h9000_0008);
  endtask

  task automatic t_perm();
    clear_all();
    put(0, 1, 32'h1000_0000, 32'h8000_0000, 12, 8'd0, 0, 8'h41);
    look(32'h1000_0010, 0, 1, 0, 0, 1, 0, 0, 0);
    check("R4 user load granted", rsp_code_o, 0);
    check("R4 user nibble", rsp_perm_o, 4'h1);
    look(32'h1000_0010, 2, 1, 0, 0, 1, 0, 0, 0);
    check("R6 user fetch exec denied", rsp_code_o, 3);
    look(32'h1000_0010, 1, 1, 0, 0, 1, 0, 0, 0);
    check("R6 user store denied", rsp_code_o, 2);
    look(32'h1000_0010, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R6 super load denied", rsp_code_o, 2);
    look(32'h1000_0010, 2, 0, 0, 0, 1, 0, 0, 0);
    check("R4 super fetch granted", rsp_code_o, 0);
    check("R4 super nibble", rsp_perm_o, 4'h4);
  endtask

  task automatic t_space();
    clear_all();
    put(0, 1, 32'h1000_0000, 32'h8000_0000, 12, 8'd0, 1, 8'h77);
    look(32'h1000_0000, 0, 0, 1, 0, 1, 0, 0, 0);
    check("R5 data space mismatch misses", rsp_code_o, 1);
    look(32'h1000_0000, 0, 0, 0, 1, 1, 0, 0, 0);
    check("R5 data space match", rsp_code_o, 0);
    look(32'h1000_0000, 2, 0, 1, 0, 1, 0, 0, 0);
    check("R5 fetch uses instruction space", rsp_code_o, 0);
  endtask

  task automatic t_modes();
    clear_all();
    put(2, 1, 32'h3000_0000, 32'h5000_0000, 12, 8'd0, 0, 8'h11);
    put(3, 1, 32'h3000_0000, 32'h6000_0000, 12, 8'd0, 0, 8'h77);
    look(32'h3000_0010, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R7 first-grant skips denier", rsp_pa_o, 32'h6000_0010);
    check("R7 first-grant code", rsp_code_o, 0);
    look(32'h3000_0010, 1, 0, 0, 0, 1, 0, 0, 1);
    check("R8 first-match reports denial", rsp_code_o, 2);
    check("R8 first-match pa", rsp_pa_o, 32'h5000_0010);
    check("R8 first-match perm", rsp_perm_o, 4'h1);
    put(3, 0, '0, '0, 0, '0, 0, '0);
    look(32'h3000_0010, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R7 fallback denial", rsp_code_o, 2);
    check("R12 removed entry not used", rsp_pa_o, 32'h5000_0010);
  endtask

  task automatic t_prio();
    clear_all();
    put(6, 1, 32'h7000_0000, 32'hB000_0000, 12, 8'd0, 0, 8'h77);
    put(5, 1, 32'h7000_0000, 32'hA000_0000, 12, 8'd0, 0, 8'h77);
    look(32'h7000_0020, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R9 lowest index wins", rsp_pa_o, 32'hA000_0020);
    put(5, 0, '0, '0, 0, '0, 0, '0);
    put(6, 0, '0, '0, 0, '0, 0, '0);
    look(32'h7000_0020, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R12 invalidated page misses", rsp_code_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_translate();
    t_pid();
    t_perm();
    t_space();
    t_modes();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule